// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block maps 16-bit virtual byte addresses onto a 22-bit physical space. The virtual space is cut into eight 8 KB segments. Each segment has a base register and a descriptor register. The descriptor holds a length limit in 64-byte blocks and an access code. Three privilege modes each own a private bank of segment registers. Inside each mode, instruction fetches and data references use two separate sets of eight segments, so each mode sees two independent 64 KB spaces. That makes 48 descriptor/base pairs in total.

Translation is purely combinational from the stored registers. An address is mapped, and its abort flag produced, in the same cycle the address is presented. When translation is switched off, addresses pass through zero-extended, except the topmost 8 KB of virtual space, which lands on the topmost 8 KB of physical space so that the peripheral page stays reachable. Software reaches every register through a simple word-wide register port at fixed octal addresses. A write is applied on the next rising clock edge and reads are combinational. This port has no flow control, so it has no valid/ready back-pressure: one access completes per cycle.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset every descriptor and base register reads zero, so with translation enabled every reference aborts.
- R2: The register windows start at octal 772300 (kernel), 772200 (supervisor) and 777600 (user). Within a window, a word at offset 2*k has k in 0..7 for instruction descriptor k, 8..15 for data descriptor k-8, 16..23 for instruction base k-16 and 24..31 for data base k-24. Odd addresses and addresses outside the three windows give reg_hit=0 and read zero, and writes to them change nothing.
- R3: A descriptor word keeps only the length field in bits 14:8 and the access field in bits 2:1; every other bit reads back as zero. A base register keeps all 16 bits.
- R4: A register write changes the stored value at the next rising clock edge. Translation follows the stored value without any extra delay, in the same cycle as the address.
- R5: Virtual bits 15:13 select the segment. The mode input picks the bank (00 kernel, 01 supervisor, 11 user), and is_instr=1 picks the instruction set while 0 picks the data set.
- R6: With translation enabled, pa = base*64 + va[12:0], modulo 2^22; pa[5:0] always equals va[5:0].
- R7: With translation enabled, a reference aborts when its block number va[12:6] is greater than the length field; a block equal to the length field is allowed.
- R8: Access code 11 allows reads and writes, 01 allows reads only (a write aborts), and 00 or 10 abort every reference.
- R9: With translation enabled, mode code 10 aborts every reference.
- R10: With translation disabled abort stays 0. pa is va zero-extended, except when va[15:13]=111, where pa[21:13] are all ones and pa[12:0]=va[12:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_enable | input | 1 | 1 = translate, 0 = pass through |
| va | input | 16 | Virtual byte address |
| mode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 11 user |
| is_instr | input | 1 | 1 = instruction fetch, 0 = data reference |
| is_write | input | 1 | 1 = write reference |
| pa | output | 22 | Physical byte address |
| abort | output | 1 | Length or access violation |
| reg_addr | input | 18 | Register port byte address |
| reg_wr | input | 1 | Write strobe, applied at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| reg_hit | output | 1 | reg_addr decodes to a register |

## Verification
The hardest case to reach from the ports is the one cycle in which a descriptor is being written while an address that uses it is presented. The old value must still govern that cycle, and the new one the cycle after. The bench holds a translation steady across a write strobe and samples abort both before and after the edge. Exact length boundaries, arithmetic wrap past 2^22, and bank separation between modes and spaces are reached by programming a few chosen segments and then walking a vector table. The table holds references just inside and just outside each limit.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  localparam int unsigned NUM_MODES  = 3;
  localparam int unsigned LEN_LSB    = 8;
  localparam int unsigned ACC_LSB    = 1;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_USER   = 2'b11
  } priv_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RSV  = 2'b10,
    ACC_RW   = 2'b11
  } acc_code_e;

  // Bank number for a mode: kernel 0, supervisor 1, user 2.
  function automatic logic [1:0] bank_of(input logic [1:0] m);
    case (m)
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic access_ok(input logic [1:0] acc, input logic wr);
    case (acc)
      ACC_RW:  return 1'b1;
      ACC_RO:  return !wr;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/seg_reg_decode.sv
module seg_reg_decode #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned SEG_W    = 3,
  parameter logic [17:0] KER_BASE = 18'o772300,
  parameter logic [17:0] SUP_BASE = 18'o772200,
  parameter logic [17:0] USR_BASE = 18'o777600
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [SEG_W+2:0]   idx,
  output logic               is_base
);
  localparam int unsigned WIN_W = SEG_W + 3;  // 64-byte window: 2 groups bits, seg, byte bit

  logic [ADDR_W-WIN_W-1:0] win;
  logic [1:0]              bank;
  logic                    win_ok;

  assign win = addr[ADDR_W-1:WIN_W];

  always_comb begin
    win_ok = 1'b1;
    bank   = 2'd0;
    if (win == KER_BASE[ADDR_W-1:WIN_W])      bank = 2'd0;
    else if (win == SUP_BASE[ADDR_W-1:WIN_W]) bank = 2'd1;
    else if (win == USR_BASE[ADDR_W-1:WIN_W]) bank = 2'd2;
    else                                      win_ok = 1'b0;
  end

  // Word index inside window: [SEG_W+1] base/desc, [SEG_W] data/instr, [SEG_W-1:0] seg
  assign hit     = win_ok && !addr[0];
  assign is_base = addr[WIN_W-1];
  assign idx     = {bank, addr[WIN_W-2], addr[SEG_W:1]};
endmodule

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_reloc_pkg::*;
#(
  parameter int unsigned SEG_W  = 3,
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W+2:0]  wr_idx,
  input  logic              wr_base,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SEG_W+2:0]  rd_idx,
  input  logic              rd_base,
  output logic [WORD_W-1:0] rdata,
  input  logic [SEG_W+2:0]  lk_idx,
  output logic [LEN_W-1:0]  lk_len,
  output logic [1:0]        lk_acc,
  output logic [BASE_W-1:0] lk_base
);
  localparam int unsigned PER_MODE = 2 << SEG_W;
  localparam int unsigned NUM_DESC = NUM_MODES * PER_MODE;

  logic [LEN_W-1:0]  len_q  [NUM_DESC];
  logic [1:0]        acc_q  [NUM_DESC];
  logic [BASE_W-1:0] base_q [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic sel;
    assign sel = wr_en && (wr_idx == (SEG_W+3)'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[i]  <= '0;
        acc_q[i]  <= '0;
        base_q[i] <= '0;
      end else if (sel) begin
        if (wr_base) begin
          base_q[i] <= wdata[BASE_W-1:0];
        end else begin
          len_q[i] <= wdata[LEN_LSB +: LEN_W];
          acc_q[i] <= wdata[ACC_LSB +: 2];
        end
      end
    end
  end

  logic rd_ok, lk_ok;
  assign rd_ok = int'(rd_idx) < NUM_DESC;
  assign lk_ok = int'(lk_idx) < NUM_DESC;

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      if (rd_base) rdata[BASE_W-1:0] = base_q[rd_idx];
      else begin
        rdata[LEN_LSB +: LEN_W] = len_q[rd_idx];
        rdata[ACC_LSB +: 2]     = acc_q[rd_idx];
      end
    end
  end

  assign lk_len  = lk_ok ? len_q[lk_idx]  : '0;
  assign lk_acc  = lk_ok ? acc_q[lk_idx]  : '0;
  assign lk_base = lk_ok ? base_q[lk_idx] : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_reloc_pkg::*;
#(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned PA_W   = 22,
  parameter int unsigned SEG_W  = 3,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned BASE_W = 16
) (
  input  logic                          en,
  input  logic                          mode_bad,
  input  logic                          is_write,
  input  logic [VA_W-1:0]               va,
  input  logic [VA_W-SEG_W-OFF_W-1:0]   len,
  input  logic [1:0]                    acc,
  input  logic [BASE_W-1:0]             base,
  output logic [PA_W-1:0]               pa,
  output logic                          abort
);
  localparam int unsigned SPAN_W = VA_W - SEG_W;
  localparam int unsigned BLK_W  = SPAN_W - OFF_W;

  logic [BLK_W-1:0] blk;
  logic [PA_W-1:0]  mapped, passed;
  logic             top_seg;

  assign blk     = va[SPAN_W-1:OFF_W];
  assign mapped  = PA_W'({base, {OFF_W{1'b0}}}) + PA_W'(va[SPAN_W-1:0]);
  assign top_seg = &va[VA_W-1:SPAN_W];
  assign passed  = top_seg ? {{(PA_W-SPAN_W){1'b1}}, va[SPAN_W-1:0]}
                           : PA_W'(va);

  always_comb begin
    if (en) begin
      pa    = mapped;
      abort = mode_bad || (blk > len) || !access_ok(acc, is_write);
    end else begin
      pa    = passed;
      abort = 1'b0;
    end
  end
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_reloc_pkg::*;
#(
  parameter int unsigned VA_W     = 16,
  parameter int unsigned PA_W     = 22,
  parameter int unsigned SEG_W    = 3,
  parameter int unsigned OFF_W    = 6,
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned WORD_W   = 16,
  parameter logic [17:0] KER_BASE = 18'o772300,
  parameter logic [17:0] SUP_BASE = 18'o772200,
  parameter logic [17:0] USR_BASE = 18'o777600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_enable,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        mode,
  input  logic              is_instr,
  input  logic              is_write,
  output logic [PA_W-1:0]   pa,
  output logic              abort,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_hit
);
  localparam int unsigned LEN_W = VA_W - SEG_W - OFF_W;
  localparam int unsigned IDX_W = SEG_W + 3;

  logic [IDX_W-1:0]  bus_idx, lk_idx;
  logic              bus_base;
  logic [WORD_W-1:0] bank_rdata;
  logic [LEN_W-1:0]  sel_len;
  logic [1:0]        sel_acc;
  logic [BASE_W-1:0] sel_base;
  logic              mode_bad;

  seg_reg_decode #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W),
    .KER_BASE(KER_BASE), .SUP_BASE(SUP_BASE), .USR_BASE(USR_BASE)
  ) u_dec (
    .addr(reg_addr), .hit(reg_hit), .idx(bus_idx), .is_base(bus_base)
  );

  assign lk_idx   = {bank_of(mode), !is_instr, va[VA_W-1 -: SEG_W]};
  assign mode_bad = (mode == MODE_BAD);

  seg_desc_bank #(
    .SEG_W(SEG_W), .LEN_W(LEN_W), .BASE_W(BASE_W), .WORD_W(WORD_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && reg_hit), .wr_idx(bus_idx), .wr_base(bus_base),
    .wdata(reg_wdata),
    .rd_idx(bus_idx), .rd_base(bus_base), .rdata(bank_rdata),
    .lk_idx(lk_idx), .lk_len(sel_len), .lk_acc(sel_acc), .lk_base(sel_base)
  );

  assign reg_rdata = reg_hit ? bank_rdata : '0;

  seg_xlate #(
    .VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)
  ) u_xl (
    .en(xl_enable), .mode_bad(mode_bad), .is_write(is_write), .va(va),
    .len(sel_len), .acc(sel_acc), .base(sel_base), .pa(pa), .abort(abort)
  );
endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xl_enable,
  input logic [15:0] va,
  input logic [1:0]  mode,
  input logic        is_write,
  input logic [21:0] pa,
  input logic        abort,
  input logic [17:0] reg_addr,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        reg_hit,
  input logic [6:0]  sel_len,
  input logic [1:0]  sel_acc
);
  AST_PASS_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_enable |-> !abort);  // R10
  AST_PASS_IO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_enable && va[15:13] == 3'b111) |-> (pa[21:13] == 9'h1FF && pa[12:0] == va[12:0]));  // R10
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    xl_enable |-> pa[5:0] == va[5:0]);  // R6
  AST_LENGTH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_enable && va[12:6] > sel_len) |-> abort);  // R7
  AST_RO_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_enable && is_write && sel_acc == 2'b01) |-> abort);  // R8
  AST_BAD_MODE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_enable && mode == 2'b10) |-> abort);  // R9
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> reg_rdata == 16'h0);  // R2
  AST_BASE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_hit && reg_addr[5]) |=>
      (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));  // R4
endmodule

bind seg_reloc_unit seg_reloc_chk u_chk (.*);

// File: tb/seg_reloc_unit_test.sv
module seg_reloc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_enable = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  mode = '0;
  logic        is_instr = 1'b0;
  logic        is_write = 1'b0;
  logic [21:0] pa;
  logic        abort;
  logic [17:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_hit;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  seg_reloc_unit uut (
    .clk(clk), .rst_n(rst_n), .xl_enable(xl_enable), .va(va), .mode(mode),
    .is_instr(is_instr), .is_write(is_write), .pa(pa), .abort(abort),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_hit(reg_hit)
  );

  // {en, mode, instr, write, va, check_pa, abort, pa}
  localparam int NV = 19;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 2'b00, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 22'h004000},  // R5 R6
    {1'b1, 2'b00, 1'b1, 1'b1, 16'h1FFF, 1'b1, 1'b0, 22'h005FFF},  // R7 R8 full length rw
    {1'b1, 2'b00, 1'b0, 1'b0, 16'h00C5, 1'b1, 1'b0, 22'h0080C5},  // R7 block == len
    {1'b1, 2'b00, 1'b0, 1'b0, 16'h0100, 1'b1, 1'b1, 22'h008100},  // R7 block > len
    {1'b1, 2'b00, 1'b0, 1'b1, 16'h0010, 1'b1, 1'b1, 22'h008010},  // R8 write to read-only
    {1'b1, 2'b00, 1'b0, 1'b1, 16'h3FFF, 1'b1, 1'b0, 22'h001FBF},  // R6 wrap
    {1'b1, 2'b01, 1'b1, 1'b0, 16'h4000, 1'b1, 1'b0, 22'h001000},  // R5 R7 zero length
    {1'b1, 2'b01, 1'b1, 1'b0, 16'h403F, 1'b1, 1'b0, 22'h00103F},  // R7
    {1'b1, 2'b01, 1'b1, 1'b0, 16'h4040, 1'b1, 1'b1, 22'h001040},  // R7
    {1'b1, 2'b11, 1'b0, 1'b1, 16'hE280, 1'b1, 1'b0, 22'h048F80},  // R5 R6
    {1'b1, 2'b11, 1'b0, 1'b0, 16'hE2C0, 1'b1, 1'b1, 22'h048FC0},  // R7
    {1'b1, 2'b11, 1'b1, 1'b0, 16'h6000, 1'b1, 1'b1, 22'h000400},  // R8 code 10
    {1'b1, 2'b00, 1'b0, 1'b0, 16'h4000, 1'b1, 1'b1, 22'h000000},  // R1 untouched segment
    {1'b1, 2'b01, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 22'h000000},  // R5 other mode's bank
    {1'b1, 2'b10, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 22'h000000},  // R9
    {1'b0, 2'b00, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 22'h001234},  // R10
    {1'b0, 2'b00, 1'b0, 1'b1, 16'hE000, 1'b1, 1'b0, 22'h3FE000},  // R10 top page
    {1'b0, 2'b10, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, 22'h3FFFFF},  // R10
    {1'b0, 2'b11, 1'b0, 1'b0, 16'hDFFF, 1'b1, 1'b0, 22'h00DFFF}   // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [17:0] a,
                          input logic hit_exp, input logic [15:0] d_exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(tag, {31'b0, reg_hit}, {31'b0, hit_exp});
    check(tag, {16'b0, reg_rdata}, {16'b0, d_exp});
  endtask

  task automatic xl_check(input string tag, input logic e, input logic [1:0] m,
                          input logic ins, input logic w, input logic [15:0] v,
                          input logic cp, input logic ab, input logic [21:0] p);
    @(negedge clk);
    xl_enable = e; mode = m; is_instr = ins; is_write = w; va = v;
    #2;
    check(tag, {31'b0, abort}, {31'b0, ab});
    if (cp) check(tag, {10'b0, pa}, {10'b0, p});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd_check("R1 kernel I desc0 after reset", 18'o772300, 1'b1, 16'h0000);
    rd_check("R1 user D base7 after reset", 18'o777676, 1'b1, 16'h0000);
    xl_check("R1 reset aborts", 1'b1, 2'b00, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 22'h0);

    // program chosen segments
    wr_reg(18'o772300, 16'h7F06); wr_reg(18'o772340, 16'h0100);  // kernel I0
    wr_reg(18'o772320, 16'h0302); wr_reg(18'o772360, 16'h0200);  // kernel D0
    wr_reg(18'o772322, 16'h7F06); wr_reg(18'o772362, 16'hFFFF);  // kernel D1
    wr_reg(18'o772204, 16'h0006); wr_reg(18'o772244, 16'h0040);  // super I2
    wr_reg(18'o777636, 16'h0A06); wr_reg(18'o777676, 16'h1234);  // user D7
    wr_reg(18'o777606, 16'h7F04); wr_reg(18'o777646, 16'h0010);  // user I3

    // R2: readback through the map
    rd_check("R2 user D base7", 18'o777676, 1'b1, 16'h1234);
    rd_check("R2 super I desc2", 18'o772204, 1'b1, 16'h0006);
    rd_check("R2 kernel D base1", 18'o772362, 1'b1, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      xl_check($sformatf("R5-table vector %0d", i), v[44], v[43:42], v[41], v[40],
               v[39:24], v[23], v[22], v[21:0]);
    end

    // R3: unimplemented descriptor bits read zero
    wr_reg(18'o772332, 16'hFFFF);
    rd_check("R3 descriptor mask", 18'o772332, 1'b1, 16'h7F06);

    // R2: odd and outside addresses
    rd_check("R2 outside window", 18'o772400, 1'b0, 16'h0000);
    wr_reg(18'o772341, 16'hAAAA);
    rd_check("R2 odd address miss", 18'o772341, 1'b0, 16'h0000);
    rd_check("R2 odd write ignored", 18'o772340, 1'b1, 16'h0100);
    wr_reg(18'o773300, 16'h5555);
    rd_check("R2 outside write ignored", 18'o772300, 1'b1, 16'h7F06);

    // R4: write applies at the next edge; translation follows at once
    @(negedge clk);
    xl_enable = 1'b1; mode = 2'b00; is_instr = 1'b0; is_write = 1'b0; va = 16'h6000;
    reg_addr = 18'o772326; reg_wdata = 16'h7F06; reg_wr = 1'b1;
    #2 check("R4 old value before edge", {31'b0, abort}, 32'd1);
    @(posedge clk);
    #1 reg_wr = 1'b0;
    #1 check("R4 new value after edge", {31'b0, abort}, 32'd0);
    check("R4 pa after edge", {10'b0, pa}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule